// File: doc/BRIEF.md
# Combined Arithmetic/Logic Unit

This block is a purely combinational ALU of parameterised width. It takes two operands, a carry input and a three-bit operation select. The top select bit chooses between an arithmetic half and a logic half. The arithmetic half has a single parallel ripple adder. That adder always sums operand A, a word Y shaped bit by bit from operand B, and the carry input. Steering Y between zeros, B, the inverse of B and ones, together with the carry input, gives eight arithmetic operations from that one adder: transfer, increment, add, add plus one, add inverse, subtract, decrement, and a second transfer.

The logic half applies one of four bitwise functions, chosen by the same two low select bits the arithmetic half uses. A datapath places the block between its operand buses and its result bus. Any output register belongs to the surrounding pipeline.

Top module: `alu_core`

## Requirements
- R1: With sel[2]=0, result equals (a_in + Y + carry_in) modulo 2^WIDTH.
- R2: Y is selected by sel[1:0]: 2'b00 gives all zeros, 2'b01 gives b_in, 2'b10 gives ~b_in, and 2'b11 gives all ones. Each bit is Y_i = (b_i & sel[0]) | (~b_i & sel[1]).
- R3: With sel[2]=0, carry_out is the carry leaving the most significant adder stage, that is bit WIDTH of a_in + Y + carry_in.
- R4: The code {sel[2],sel[1],sel[0],carry_in} gives these results:
  - 0000 gives A
  - 0001 gives A+1
  - 0010 gives A+B
  - 0011 gives A+B+1
  - 0100 gives A+~B
  - 0101 gives A-B
  - 0110 gives A-1
  - 0111 gives A
- R5: With sel[2]=1, sel[1:0] selects a bitwise function: 2'b00 gives a_in&b_in, 2'b01 gives a_in|b_in, 2'b10 gives a_in^b_in, and 2'b11 gives ~a_in.
- R6: With sel[2]=1, carry_in has no effect on result.
- R7: With sel[2]=1, carry_out is 0.
- R8: The behaviour above holds for any WIDTH; the default is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| carry_in | input | 1 | Carry into the least significant adder stage |
| sel | input | 3 | Operation select; bit 2 picks logic (1) or arithmetic (0) |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top adder stage; 0 in logic mode |

## Verification
The bench targets several carry corners:
- A carry rippling through every stage, as in 0xFF plus 1, would leave a wrong top bit or a lost carry_out if one adder stage were miswired.
- Subtracting zero from zero and decrementing zero test the inverse-plus-one and all-ones paths of Y. A swapped select decode turns these into additions.
- Logic mode is run with both carry_in values. Leakage of the adder carry or of carry_in into the logic path would then show as a changed result or a set carry_out.

A four-bit instance is swept over every operand pair, code and carry. This catches a per-bit Y or logic-mux error that random eight-bit operands might miss.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_XOR  = 2'b10,
    FN_NOTA = 2'b11
  } logic_fn_e;

  localparam int MODE_BIT = 2;
endpackage

// File: rtl/alu_bsel.sv
module alu_bsel #(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       fsel,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign y[i] = (b[i] & fsel[0]) | (~b[i] & fsel[1]);
    end
  endgenerate

  always_comb begin
    case (fsel)
      2'b00: begin
        // R2
        y_zero_chk: assert (y == '0) else $error("Y not zero");
      end
      2'b01: begin
        // R2
        y_pass_chk: assert (y == b) else $error("Y not B");
      end
      2'b10: begin
        // R2
        y_inv_chk: assert ((y ^ b) == '1) else $error("Y not ~B");
      end
      default: begin
        // R2
        y_ones_chk: assert (&y) else $error("Y not ones");
      end
    endcase
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int W1 = WIDTH + 1;

  logic [WIDTH:0] chain;
  assign chain[0] = cin;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_fa
      assign sum[i]     = a[i] ^ y[i] ^ chain[i];
      assign chain[i+1] = (a[i] & y[i]) | (chain[i] & (a[i] ^ y[i]));
    end
  endgenerate

  assign cout = chain[WIDTH];

  logic [WIDTH:0] wide_sum;
  always_comb begin
    wide_sum = W1'(a) + W1'(y) + W1'(cin);
    // R1
    add_sum_chk: assert (sum == wide_sum[WIDTH-1:0]) else $error("adder sum");
    // R3
    add_carry_chk: assert (cout == wide_sum[WIDTH]) else $error("adder carry");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [1:0]       fsel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic [3:0] choices;
      assign choices = {~a[i], a[i] ^ b[i], a[i] | b[i], a[i] & b[i]};
      assign g[i] = choices[fsel];
    end
  endgenerate

  always_comb begin
    if (logic_fn_e'(fsel) == FN_NOTA) begin
      // R5
      logic_not_chk: assert ((g ^ a) == '1) else $error("NOT A");
    end
    if (logic_fn_e'(fsel) == FN_AND) begin
      // R5
      logic_and_chk: assert ((g & ~a) == '0 && (g & ~b) == '0) else $error("AND");
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] y_word;
  logic [WIDTH-1:0] arith_g;
  logic [WIDTH-1:0] logic_g;
  logic             arith_c;
  logic             logic_mode;

  assign logic_mode = sel[MODE_BIT];

  alu_bsel #(.WIDTH(WIDTH)) u_bsel (
    .fsel (sel[1:0]),
    .b    (b_in),
    .y    (y_word)
  );

  alu_ripple #(.WIDTH(WIDTH)) u_adder (
    .a    (a_in),
    .y    (y_word),
    .cin  (carry_in),
    .sum  (arith_g),
    .cout (arith_c)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .fsel (sel[1:0]),
    .a    (a_in),
    .b    (b_in),
    .g    (logic_g)
  );

  assign result    = logic_mode ? logic_g : arith_g;
  assign carry_out = logic_mode ? 1'b0 : arith_c;

  always_comb begin
    if (logic_mode) begin
      // R7
      logic_cout_chk: assert (!carry_out) else $error("carry in logic mode");
    end
    if (!logic_mode && sel[1:0] == 2'b11 && carry_in) begin
      // R4
      xfer_chk: assert (result == a_in && carry_out) else $error("transfer code 0111");
    end
    if (!logic_mode && sel[1:0] == 2'b00 && !carry_in) begin
      // R4
      xfer0_chk: assert (result == a_in && !carry_out) else $error("transfer code 0000");
    end
  end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0] a8 = '0, b8 = '0, g8;
  logic       c8 = 1'b0, co8;
  logic [2:0] s8 = '0;
  logic [3:0] a4 = '0, b4 = '0, g4;
  logic       c4 = 1'b0, co4;
  logic [2:0] s4 = '0;

  alu_core #(.WIDTH(8)) dut (
    .a_in(a8), .b_in(b8), .carry_in(c8), .sel(s8), .result(g8), .carry_out(co8));
  alu_core #(.WIDTH(4)) dut_w4 (
    .a_in(a4), .b_in(b4), .carry_in(c4), .sel(s4), .result(g4), .carry_out(co4));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_model(input int w, input int a, input int b,
                                   input int cin, input int sel);
    int mask, y, s, g, co;
    mask = (1 << w) - 1;
    co = 0;
    if (sel < 4) begin
      case (sel)
        0: y = 0;
        1: y = b;
        2: y = ~b & mask;
        default: y = mask;
      endcase
      s  = a + y + cin;
      g  = s & mask;
      co = (s >> w) & 1;
    end else begin
      case (sel - 4)
        0: g = a & b;
        1: g = a | b;
        2: g = a ^ b;
        default: g = ~a & mask;
      endcase
    end
    return (co << 16) | g;
  endfunction

  task automatic run8(input int a, input int b, input int cin, input int sel);
    @(negedge clk);
    a8 = a[7:0]; b8 = b[7:0]; c8 = cin[0]; s8 = sel[2:0];
    #5;
  endtask

  task automatic expect8(input string req, input int g, input int co);
    check(req, int'(g8), g);
    check(req, int'(co8), co);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #5;
    // R1 idle output with all-zero inputs
    expect8("R1 idle", 0, 0);

    // R2 Y selection seen through A=0, Cin=0
    run8(0, 'h5A, 0, 0); expect8("R2 zeros", 'h00, 0);
    run8(0, 'h5A, 0, 1); expect8("R2 B",     'h5A, 0);
    run8(0, 'h5A, 0, 2); expect8("R2 ~B",    'hA5, 0);
    run8(0, 'h5A, 0, 3); expect8("R2 ones",  'hFF, 0);

    // R4 named codes with A=0x37, B=0x12
    run8('h37, 'h12, 0, 0); expect8("R4 0000", 'h37, 0);
    run8('h37, 'h12, 1, 0); expect8("R4 0001", 'h38, 0);
    run8('h37, 'h12, 0, 1); expect8("R4 0010", 'h49, 0);
    run8('h37, 'h12, 1, 1); expect8("R4 0011", 'h4A, 0);
    run8('h37, 'h12, 0, 2); expect8("R4 0100", 'h24, 1);
    run8('h37, 'h12, 1, 2); expect8("R4 0101", 'h25, 1);
    run8('h37, 'h12, 0, 3); expect8("R4 0110", 'h36, 1);
    run8('h37, 'h12, 1, 3); expect8("R4 0111", 'h37, 1);

    // R3 carry corners
    run8('hFF, 'h01, 0, 1); expect8("R3 full ripple", 'h00, 1);
    run8('h00, 'h00, 1, 2); expect8("R3 zero minus zero", 'h00, 1);
    run8('h00, 'h00, 0, 3); expect8("R3 decrement zero", 'hFF, 0);

    // R5 logic functions with A=0xC3, B=0xA5
    run8('hC3, 'hA5, 0, 4); expect8("R5 AND", 'h81, 0);
    run8('hC3, 'hA5, 0, 5); expect8("R5 OR",  'hE7, 0);
    run8('hC3, 'hA5, 0, 6); expect8("R5 XOR", 'h66, 0);
    run8('hC3, 'hA5, 0, 7); expect8("R5 NOT", 'h3C, 0);

    // R7 no carry in logic mode even with all-ones operands
    for (int op = 4; op < 8; op++) begin
      run8('hFF, 'hFF, 1, op);
      check("R7 carry zero", int'(co8), 0);
    end

    // R6 carry_in ignored in logic mode
    for (int k = 0; k < 64; k++) begin
      int ra, rb, op, g0;
      ra = int'($urandom_range(255));
      rb = int'($urandom_range(255));
      op = 4 + (k % 4);
      run8(ra, rb, 0, op); g0 = int'(g8);
      run8(ra, rb, 1, op);
      check("R6 cin ignored", int'(g8), g0);
    end

    // R1 R3 R5 R7 random 8-bit operands over every code
    for (int k = 0; k < 150; k++) begin
      int ra, rb, e;
      ra = int'($urandom_range(255));
      rb = int'($urandom_range(255));
      for (int code = 0; code < 16; code++) begin
        run8(ra, rb, code & 1, code >> 1);
        e = ref_model(8, ra, rb, code & 1, code >> 1);
        if (code < 8) expect8("R1 R3 random arith", e & 'hFFFF, e >> 16);
        else          expect8("R5 R7 random logic", e & 'hFFFF, e >> 16);
      end
    end

    // R8 exhaustive sweep of the 4-bit instance
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int code = 0; code < 16; code++) begin
          int e;
          @(negedge clk);
          a4 = a[3:0]; b4 = b[3:0]; c4 = code[0]; s4 = code[3:1];
          #5;
          e = ref_model(4, a, b, code & 1, code >> 1);
          check("R8 width 4 result", int'(g4), e & 'hFFFF);
          check("R8 width 4 carry", int'(co4), e >> 16);
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule